// File: doc/BRIEF.md
# SCSI Controller Register Front-End

This block is the host-facing byte register file and command decoder of a SCSI bus controller. The host reaches sixteen byte-wide slots through a narrow address; a read and a write to the same slot may reach different storage. The block holds a 16-bit transfer counter with a separate start value, the status, interrupt-reason, sequence-step and FIFO-fill registers, three configuration areas and a small byte FIFO. It drives one interrupt line toward the host.

Command bytes written to the command slot are split into a DMA flag and a 7-bit operation. Flush, chip reset and bus reset act locally. Every recognised operation is also handed to the bus sequencer as a one-cycle strobe. The completion of a DMA burst arrives as a single-cycle input, and the block then updates its status and raises the interrupt.

Top module: `scsi_regfront`

## Requirements
- R1: The slot index is `bus_addr[SLOT_LSB+3:SLOT_LSB]`. Reads return: 0 count low byte, 1 count middle byte, 2 FIFO head (0 when empty), 3 last command byte, 4 status, 5 interrupt reason, 6 sequence step, 7 FIFO fill count, 8 config 1, 0xB config 2, 0xC–0xF the upper config bytes, 9 and 0xA zero. `bus_rdata` is combinational from the current state.
- R2: After reset every register is zero, `irq` is low and the FIFO is empty, except slot 0xE, which reads 0x04 (parameter `CHIP_ID`).
- R3: Command byte bit 7 is the DMA flag and `cmd_dma` holds it. When the flag is set, the current count is loaded from the start count held by slots 0/1 in the next cycle. `xfer_len` shows the current count, and a count of zero shows as 65536.
- R4: The recognised operations are 0x00, 0x01, 0x02, 0x03, 0x10, 0x11, 0x12, 0x1A, 0x42, 0x43 and 0x44. A recognised operation gives a one-cycle `cmd_valid` with `cmd_code` in the cycle after the write. Any other code gives no strobe and sets status bit 0x40 (gross error).
- R5: Flush (0x01) sets the interrupt reason to 0x08, sets the sequence step to 0 and empties the FIFO.
- R6: Bus reset (0x03) sets the interrupt reason to 0x80. It raises `irq` only when config 1 bit 6 (0x40) is clear.
- R7: Chip reset (0x02) returns every register and the FIFO to the R2 values and clears `irq`, but still strobes `cmd_valid` with code 0x02.
- R8: Reading slot 5 clears status bits 0x80 (interrupt), 0x40 (gross error) and 0x20 (parity) and deasserts `irq`.
- R9: Writing slot 0 or 1 stores the low or middle start-count byte and clears status bit 0x10 (terminal count).
- R10: Writes to slots 4–7 load target ID (bits 2:0), selection timeout, sync period and sync offset, shown on their output ports. They leave the readable registers of those slots unchanged.
- R11: Config 1 and slots 0xC–0xF store the written byte. Config 2 keeps only the bits under mask 0x15. Writes to slots 9 and 0xA are ignored.
- R12: Writing slot 2 pushes into a FIFO_DEPTH-byte FIFO and the byte is dropped when the FIFO is full. Reading slot 2 returns the head and pops it.
- R13: `dma_done` ORs 0x90 into status, sets the interrupt reason to 0x10, clears the sequence step, the current count and the FIFO, and raises `irq`. It acts after any host access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | SLOT_LSB+4 | Host byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed slot |
| dma_done | input | 1 | One-cycle DMA burst completion |
| irq | output | 1 | Interrupt to host |
| cmd_valid | output | 1 | One-cycle recognised-command strobe |
| cmd_code | output | 7 | Operation of the last recognised command |
| cmd_dma | output | 1 | DMA flag of the last command byte |
| xfer_len | output | 17 | Current transfer length (0 shown as 65536) |
| target_id | output | 3 | Target bus ID |
| sel_timeout | output | 8 | Selection timeout |
| sync_period | output | 8 | Synchronous transfer period |
| sync_offset | output | 8 | Synchronous transfer offset |

## Verification
A DMA completion can land in the same cycle as a host access. The interesting cases are a read of the interrupt-reason slot, a write to a count slot, and a FIFO push. The bench drives `dma_done` together with each of these accesses, on purpose and also in the random phase. Its model applies the host effect first and the completion after it. The bench then expects `irq` to stay high, the terminal-count bit to stay set and the FIFO to end up empty.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

    // slot indices whose meaning the logic depends on
    localparam logic [3:0] SL_CNT_LO  = 4'h0;
    localparam logic [3:0] SL_CNT_MID = 4'h1;
    localparam logic [3:0] SL_FIFO    = 4'h2;
    localparam logic [3:0] SL_CMD     = 4'h3;
    localparam logic [3:0] SL_STAT    = 4'h4;  // write: target id
    localparam logic [3:0] SL_INTR    = 4'h5;  // write: selection timeout
    localparam logic [3:0] SL_SEQ     = 4'h6;  // write: sync period
    localparam logic [3:0] SL_FLAGS   = 4'h7;  // write: sync offset
    localparam logic [3:0] SL_CFG1    = 4'h8;
    localparam logic [3:0] SL_CFG2    = 4'hB;

    // status bits
    localparam logic [7:0] ST_INT  = 8'h80;
    localparam logic [7:0] ST_GERR = 8'h40;
    localparam logic [7:0] ST_PERR = 8'h20;
    localparam logic [7:0] ST_TC   = 8'h10;

    // interrupt reason codes
    localparam logic [7:0] IR_FUNC_DONE = 8'h08;
    localparam logic [7:0] IR_SERVICE   = 8'h10;
    localparam logic [7:0] IR_BUS_RST   = 8'h80;

    localparam logic [7:0] CFG2_KEEP    = 8'h15;
    localparam int unsigned CFG1_QUIET  = 6;

    // operation codes
    localparam logic [6:0] OP_NOP     = 7'h00;
    localparam logic [6:0] OP_FLUSH   = 7'h01;
    localparam logic [6:0] OP_CHIPRST = 7'h02;
    localparam logic [6:0] OP_BUSRST  = 7'h03;
    localparam logic [6:0] OP_XFER    = 7'h10;
    localparam logic [6:0] OP_CMPL    = 7'h11;
    localparam logic [6:0] OP_MSGOK   = 7'h12;
    localparam logic [6:0] OP_ATN     = 7'h1A;
    localparam logic [6:0] OP_SELATN  = 7'h42;
    localparam logic [6:0] OP_SELSTOP = 7'h43;
    localparam logic [6:0] OP_ENSEL   = 7'h44;

    typedef enum logic [2:0] {
        CK_NOP,
        CK_FLUSH,
        CK_CHIPRST,
        CK_BUSRST,
        CK_PASS,
        CK_BAD
    } cmd_kind_e;

    typedef struct packed {
        logic [15:0]     cnt_start;
        logic [15:0]     cnt_cur;
        logic [7:0]      status;
        logic [7:0]      intr;
        logic [7:0]      seq;
        logic [7:0]      cmd_last;
        logic [7:0]      cfg1;
        logic [7:0]      cfg2;
        logic [3:0][7:0] cfg_hi;
        logic [2:0]      bus_id;
        logic [7:0]      sel_tmo;
        logic [7:0]      sync_per;
        logic [7:0]      sync_off;
        logic            irq;
        logic            cmd_pulse;
        logic            cmd_dma;
        logic [6:0]      cmd_code;
    } regs_t;

    function automatic regs_t regs_reset(input logic [7:0] id);
        regs_t r;
        r = '0;
        r.cfg_hi[2] = id;
        return r;
    endfunction

endpackage

// File: rtl/scsi_rf_fifo.sv
module scsi_rf_fifo #(
    parameter int unsigned DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           push,
    input  logic [7:0]                     wdata,
    input  logic                           pop,
    output logic [7:0]                     head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    // DEPTH must be a power of two so the pointers wrap naturally
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t   f_q, f_d;
    logic [7:0] mem_q [DEPTH];
    logic       do_push, do_pop;

    assign full    = (f_q.cnt == CNT_W'(DEPTH));
    assign empty   = (f_q.cnt == '0);
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign head    = mem_q[f_q.rp];
    assign count   = f_q.cnt;

    always_comb begin
        f_d = f_q;
        if (clear) begin
            f_d = '0;
        end else begin
            if (do_push) f_d.wp = f_q.wp + PTR_W'(1);
            if (do_pop)  f_d.rp = f_q.rp + PTR_W'(1);
            f_d.cnt = f_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[f_q.wp] <= wdata;
    end

endmodule

// File: rtl/scsi_rf_cmd_dec.sv
module scsi_rf_cmd_dec
    import scsi_rf_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output logic       dma_sel,
    output logic [6:0] op,
    output cmd_kind_e  kind
);
    assign dma_sel = cmd_byte[7];
    assign op      = cmd_byte[6:0];

    always_comb begin
        case (op)
            OP_NOP:     kind = CK_NOP;
            OP_FLUSH:   kind = CK_FLUSH;
            OP_CHIPRST: kind = CK_CHIPRST;
            OP_BUSRST:  kind = CK_BUSRST;
            OP_XFER, OP_CMPL, OP_MSGOK, OP_ATN,
            OP_SELATN, OP_SELSTOP, OP_ENSEL:
                        kind = CK_PASS;
            default:    kind = CK_BAD;
        endcase
    end

endmodule

// File: rtl/scsi_rf_rdmux.sv
module scsi_rf_rdmux
    import scsi_rf_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic [3:0]       slot,
    input  logic [15:0]      cnt_cur,
    input  logic [7:0]       cmd_last,
    input  logic [7:0]       status,
    input  logic [7:0]       intr,
    input  logic [7:0]       seq,
    input  logic [7:0]       cfg1,
    input  logic [7:0]       cfg2,
    input  logic [3:0][7:0]  cfg_hi,
    input  logic [7:0]       fifo_head,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             fifo_empty,
    output logic [7:0]       rdata
);
    always_comb begin
        case (slot)
            SL_CNT_LO:  rdata = cnt_cur[7:0];
            SL_CNT_MID: rdata = cnt_cur[15:8];
            SL_FIFO:    rdata = fifo_empty ? 8'h00 : fifo_head;
            SL_CMD:     rdata = cmd_last;
            SL_STAT:    rdata = status;
            SL_INTR:    rdata = intr;
            SL_SEQ:     rdata = seq;
            SL_FLAGS:   rdata = 8'(fifo_cnt);
            SL_CFG1:    rdata = cfg1;
            SL_CFG2:    rdata = cfg2;
            4'hC, 4'hD, 4'hE, 4'hF:
                        rdata = cfg_hi[slot[1:0]];
            default:    rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
    import scsi_rf_pkg::*;
#(
    parameter int unsigned SLOT_LSB   = 2,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter logic [7:0]  CHIP_ID    = 8'h04
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [SLOT_LSB+3:0]   bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic                  dma_done,
    output logic                  irq,
    output logic                  cmd_valid,
    output logic [6:0]            cmd_code,
    output logic                  cmd_dma,
    output logic [16:0]           xfer_len,
    output logic [2:0]            target_id,
    output logic [7:0]            sel_timeout,
    output logic [7:0]            sync_period,
    output logic [7:0]            sync_offset
);
    localparam int unsigned FCNT_W = $clog2(FIFO_DEPTH + 1);

    regs_t             st_q, st_d;
    logic [3:0]        acc_slot;
    logic              unused_addr_lo;
    logic              rd_acc, wr_acc;

    logic              dec_dma;
    logic [6:0]        dec_op;
    cmd_kind_e         dec_kind;

    logic              fifo_clr, fifo_push, fifo_pop;
    logic [7:0]        fifo_head;
    logic [FCNT_W-1:0] fifo_cnt;
    logic              fifo_full, fifo_empty;

    assign acc_slot       = bus_addr[SLOT_LSB +: 4];
    assign unused_addr_lo = ^bus_addr[SLOT_LSB-1:0];
    assign rd_acc         = bus_sel && !bus_wr;
    assign wr_acc         = bus_sel && bus_wr;

    scsi_rf_cmd_dec u_dec (
        .cmd_byte (bus_wdata),
        .dma_sel  (dec_dma),
        .op       (dec_op),
        .kind     (dec_kind)
    );

    scsi_rf_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (fifo_clr),
        .push  (fifo_push),
        .wdata (bus_wdata),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    scsi_rf_rdmux #(
        .CNT_W (FCNT_W)
    ) u_rdmux (
        .slot       (acc_slot),
        .cnt_cur    (st_q.cnt_cur),
        .cmd_last   (st_q.cmd_last),
        .status     (st_q.status),
        .intr       (st_q.intr),
        .seq        (st_q.seq),
        .cfg1       (st_q.cfg1),
        .cfg2       (st_q.cfg2),
        .cfg_hi     (st_q.cfg_hi),
        .fifo_head  (fifo_head),
        .fifo_cnt   (fifo_cnt),
        .fifo_empty (fifo_empty),
        .rdata      (bus_rdata)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cmd_pulse = 1'b0;
        fifo_push      = 1'b0;
        fifo_pop       = 1'b0;
        fifo_clr       = 1'b0;

        // host reads with side effects
        if (rd_acc) begin
            case (acc_slot)
                SL_FIFO: fifo_pop = !fifo_empty;
                SL_INTR: begin
                    st_d.status = st_q.status & ~(ST_INT | ST_GERR | ST_PERR);
                    st_d.irq    = 1'b0;
                end
                default: ;
            endcase
        end

        // host writes
        if (wr_acc) begin
            case (acc_slot)
                SL_CNT_LO: begin
                    st_d.cnt_start[7:0] = bus_wdata;
                    st_d.status         = st_q.status & ~ST_TC;
                end
                SL_CNT_MID: begin
                    st_d.cnt_start[15:8] = bus_wdata;
                    st_d.status          = st_q.status & ~ST_TC;
                end
                SL_FIFO: fifo_push = !fifo_full;
                SL_CMD: begin
                    st_d.cmd_last = bus_wdata;
                    st_d.cmd_dma  = dec_dma;
                    if (dec_dma) st_d.cnt_cur = st_q.cnt_start;
                    case (dec_kind)
                        CK_FLUSH: begin
                            st_d.intr = IR_FUNC_DONE;
                            st_d.seq  = 8'h00;
                            fifo_clr  = 1'b1;
                        end
                        CK_CHIPRST: begin
                            st_d     = regs_reset(CHIP_ID);
                            fifo_clr = 1'b1;
                        end
                        CK_BUSRST: begin
                            st_d.intr = IR_BUS_RST;
                            if (!st_q.cfg1[CFG1_QUIET]) st_d.irq = 1'b1;
                        end
                        CK_BAD:  st_d.status = st_q.status | ST_GERR;
                        default: ;
                    endcase
                    if (dec_kind != CK_BAD) begin
                        st_d.cmd_pulse = 1'b1;
                        st_d.cmd_code  = dec_op;
                    end
                end
                SL_STAT:  st_d.bus_id   = bus_wdata[2:0];
                SL_INTR:  st_d.sel_tmo  = bus_wdata;
                SL_SEQ:   st_d.sync_per = bus_wdata;
                SL_FLAGS: st_d.sync_off = bus_wdata;
                SL_CFG1:  st_d.cfg1     = bus_wdata;
                SL_CFG2:  st_d.cfg2     = bus_wdata & CFG2_KEEP;
                4'hC, 4'hD, 4'hE, 4'hF:
                          st_d.cfg_hi[acc_slot[1:0]] = bus_wdata;
                default: ;
            endcase
        end

        // burst completion lands on top of any host effect
        if (dma_done) begin
            st_d.status  = st_d.status | ST_INT | ST_TC;
            st_d.intr    = IR_SERVICE;
            st_d.seq     = 8'h00;
            st_d.cnt_cur = 16'h0000;
            st_d.irq     = 1'b1;
            fifo_clr     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= regs_reset(CHIP_ID);
        else        st_q <= st_d;
    end

    assign irq         = st_q.irq;
    assign cmd_valid   = st_q.cmd_pulse;
    assign cmd_code    = st_q.cmd_code;
    assign cmd_dma     = st_q.cmd_dma;
    assign xfer_len    = (st_q.cnt_cur == 16'h0000) ? 17'h10000 : {1'b0, st_q.cnt_cur};
    assign target_id   = st_q.bus_id;
    assign sel_timeout = st_q.sel_tmo;
    assign sync_period = st_q.sync_per;
    assign sync_offset = st_q.sync_off;

endmodule

// File: rtl/scsi_regfront_chk.sv
module scsi_regfront_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [3:0]  slot,
    input logic [7:0]  wdata,
    input logic        dma_done,
    input logic        irq,
    input logic        cmd_valid,
    input logic [16:0] xfer_len,
    input logic [3:0]  st_hi,
    input logic [7:0]  intr,
    input logic [15:0] cnt_start,
    input logic        cfg1_quiet
);
    // R8: reading the interrupt reason clears the line and the error bits
    a_r8_intr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && slot == 4'h5 && !dma_done) |=> (!irq && st_hi[3:1] == 3'b000));

    // R13: burst completion
    a_r13_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> (irq && intr == 8'h10 && st_hi[3] && st_hi[0] && xfer_len == 17'h10000));

    // R9: count byte writes clear terminal count
    a_r9_count_write_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (slot == 4'h0 || slot == 4'h1) && !dma_done) |=> !st_hi[0]);

    // R3: DMA flag reloads the current count
    a_r3_dma_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && slot == 4'h3 && wdata[7] && wdata[6:0] != 7'h02 && !dma_done)
        |=> xfer_len == (($past(cnt_start) == 16'h0000) ? 17'h10000 : {1'b0, $past(cnt_start)}));

    // R6: quiet bus reset leaves the line low
    a_r6_quiet_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && slot == 4'h3 && wdata[6:0] == 7'h03 && cfg1_quiet && !irq && !dma_done)
        |=> !irq);

    // R4: a strobe only follows a command write
    a_r4_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(bus_sel && bus_wr && slot == 4'h3));

endmodule

bind scsi_regfront scsi_regfront_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .slot       (acc_slot),
    .wdata      (bus_wdata),
    .dma_done   (dma_done),
    .irq        (irq),
    .cmd_valid  (cmd_valid),
    .xfer_len   (xfer_len),
    .st_hi      (st_q.status[7:4]),
    .intr       (st_q.intr),
    .cnt_start  (st_q.cnt_start),
    .cfg1_quiet (st_q.cfg1[6])
);

// File: tb/scsi_regfront_tb_top.sv
`timescale 1ns/1ps
module scsi_regfront_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, dma_done = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq, cmd_valid, cmd_dma;
    logic [6:0]  cmd_code;
    logic [16:0] xfer_len;
    logic [2:0]  target_id;
    logic [7:0]  sel_timeout, sync_period, sync_offset;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    scsi_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_done(dma_done), .irq(irq), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_dma(cmd_dma), .xfer_len(xfer_len), .target_id(target_id),
        .sel_timeout(sel_timeout), .sync_period(sync_period), .sync_offset(sync_offset)
    );

    // ---------------- reference model ----------------
    logic [15:0] m_cs, m_cc;
    logic [7:0]  m_st, m_in, m_sq, m_cmd, m_c1, m_c2;
    logic [7:0]  m_hi [4];
    logic [2:0]  m_id;
    logic [7:0]  m_tmo, m_per, m_off;
    bit          m_irq, m_cv, m_dma;
    logic [6:0]  m_code;
    logic [7:0]  m_q [$];

    task automatic m_reset();
        m_cs = 0; m_cc = 0; m_st = 0; m_in = 0; m_sq = 0; m_cmd = 0;
        m_c1 = 0; m_c2 = 0;
        foreach (m_hi[i]) m_hi[i] = 0;
        m_hi[2] = 8'h04;
        m_id = 0; m_tmo = 0; m_per = 0; m_off = 0;
        m_irq = 0; m_cv = 0; m_dma = 0; m_code = 0;
        m_q.delete();
    endtask

    function automatic bit known_op(input logic [6:0] c);
        return c inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12,
                         7'h1A, 7'h42, 7'h43, 7'h44};
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] s);
        if (s == 0)  return m_cc[7:0];
        if (s == 1)  return m_cc[15:8];
        if (s == 2)  return (m_q.size() > 0) ? m_q[0] : 8'h00;
        if (s == 3)  return m_cmd;
        if (s == 4)  return m_st;
        if (s == 5)  return m_in;
        if (s == 6)  return m_sq;
        if (s == 7)  return 8'(m_q.size());
        if (s == 8)  return m_c1;
        if (s == 11) return m_c2;
        if (s >= 12) return m_hi[s - 12];
        return 8'h00;
    endfunction

    task automatic m_apply(input bit sel, input bit wr, input logic [3:0] s,
                           input logic [7:0] wd, input bit dd);
        m_cv = 0;
        if (sel && !wr) begin
            if (s == 2 && m_q.size() > 0) void'(m_q.pop_front());
            if (s == 5) begin m_st = m_st & 8'h1F; m_irq = 0; end
        end
        if (sel && wr) begin
            if (s == 0) begin m_cs[7:0] = wd; m_st[4] = 0; end
            else if (s == 1) begin m_cs[15:8] = wd; m_st[4] = 0; end
            else if (s == 2) begin if (m_q.size() < 16) m_q.push_back(wd); end
            else if (s == 3) begin
                m_cmd = wd; m_dma = wd[7];
                if (wd[7]) m_cc = m_cs;
                if (wd[6:0] == 7'h01) begin m_in = 8'h08; m_sq = 0; m_q.delete(); end
                else if (wd[6:0] == 7'h02) m_reset();
                else if (wd[6:0] == 7'h03) begin m_in = 8'h80; if (!m_c1[6]) m_irq = 1; end
                else if (!known_op(wd[6:0])) m_st[6] = 1;
                if (known_op(wd[6:0])) begin m_cv = 1; m_code = wd[6:0]; end
            end
            else if (s == 4) m_id = wd[2:0];
            else if (s == 5) m_tmo = wd;
            else if (s == 6) m_per = wd;
            else if (s == 7) m_off = wd;
            else if (s == 8) m_c1 = wd;
            else if (s == 11) m_c2 = wd & 8'h15;
            else if (s >= 12) m_hi[s - 12] = wd;
        end
        if (dd) begin
            m_st = m_st | 8'h90; m_in = 8'h10; m_sq = 0; m_cc = 0;
            m_irq = 1; m_q.delete();
        end
    endtask

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_outputs(input string tag);
        chk(tag, "irq", int'(irq), int'(m_irq));
        chk(tag, "cmd_valid", int'(cmd_valid), int'(m_cv));
        chk(tag, "cmd_code", int'(cmd_code), int'(m_code));
        chk(tag, "cmd_dma", int'(cmd_dma), int'(m_dma));
        chk(tag, "xfer_len", int'(xfer_len), (m_cc == 0) ? 65536 : int'(m_cc));
        chk(tag, "target_id", int'(target_id), int'(m_id));
        chk(tag, "sel_timeout", int'(sel_timeout), int'(m_tmo));
        chk(tag, "sync_period", int'(sync_period), int'(m_per));
        chk(tag, "sync_offset", int'(sync_offset), int'(m_off));
    endtask

    // one bus cycle; starts and ends just after a falling edge
    task automatic step(input bit sel, input bit wr, input logic [3:0] s,
                        input logic [7:0] wd, input bit dd, input string tag);
        bus_sel = sel; bus_wr = wr; bus_addr = {s, 2'b01}; bus_wdata = wd; dma_done = dd;
        #2;
        if (sel && !wr) chk(tag, $sformatf("read slot %0d", s), int'(bus_rdata), int'(exp_read(s)));
        @(posedge clk);
        m_apply(sel, wr, s, wd, dd);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; dma_done = 0;
        cmp_outputs(tag);
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] wd, input string tag);
        step(1, 1, s, wd, 0, tag);
    endtask

    task automatic rd(input logic [3:0] s, input string tag);
        step(1, 0, s, 8'h00, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 4'h0, 8'h00, 0, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] codes [12];
        codes = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h12, 8'h1A,
                  8'h42, 8'h43, 8'h44, 8'h55};
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_outputs("R2 reset");
        for (int s = 0; s < 16; s++) rd(4'(s), "R2 R1 reset read");

        // counter and DMA reload
        wr(4'h0, 8'h34, "R9 count low");
        wr(4'h1, 8'h12, "R9 count mid");
        idle("R3 no reload before command");
        wr(4'h3, 8'h80, "R3 R4 dma nop");
        rd(4'h0, "R1 count low read");
        rd(4'h1, "R1 count mid read");
        rd(4'h3, "R1 command read");
        wr(4'h0, 8'h00, "R9");
        wr(4'h1, 8'h00, "R9");
        wr(4'h3, 8'h00, "R3 plain nop keeps count");
        wr(4'h3, 8'h90, "R3 zero count is 65536");

        // completion and interrupt clear
        step(0, 0, 4'h0, 8'h00, 1, "R13 dma done");
        rd(4'h4, "R13 status");
        rd(4'h6, "R13 seq");
        rd(4'h5, "R8 intr read");
        rd(4'h4, "R8 status after clear");
        wr(4'h1, 8'h07, "R9 clears tc");
        rd(4'h4, "R9 status");

        // illegal code
        wr(4'h3, 8'h55, "R4 illegal code");
        rd(4'h4, "R4 gross error");
        rd(4'h5, "R8 clears gross error");
        rd(4'h4, "R8 status");
        wr(4'h3, 8'h42, "R4 select strobe");
        idle("R4 strobe one cycle");

        // FIFO
        wr(4'h2, 8'hA1, "R12 push");
        wr(4'h2, 8'hB2, "R12 push");
        wr(4'h2, 8'hC3, "R12 push");
        rd(4'h7, "R12 count");
        rd(4'h2, "R12 pop");
        rd(4'h2, "R12 pop");
        for (int i = 0; i < 17; i++) wr(4'h2, 8'(8'h10 + i), "R12 fill");
        rd(4'h7, "R12 full count");
        rd(4'h2, "R12 head after fill");
        wr(4'h3, 8'h01, "R5 flush");
        rd(4'h7, "R5 fifo empty");
        rd(4'h5, "R5 intr");
        rd(4'h2, "R12 empty read");

        // bus reset masking
        wr(4'h8, 8'h40, "R11 cfg1");
        wr(4'h3, 8'h03, "R6 quiet bus reset");
        rd(4'h5, "R6 intr code");
        wr(4'h8, 8'h00, "R11 cfg1");
        wr(4'h3, 8'h03, "R6 loud bus reset");
        rd(4'h5, "R8 clear");

        // configuration
        wr(4'hB, 8'hFF, "R11 cfg2 mask");
        rd(4'hB, "R11 cfg2 read");
        wr(4'h9, 8'hFF, "R11 slot 9 ignored");
        wr(4'hA, 8'hFF, "R11 slot A ignored");
        rd(4'h9, "R11");
        rd(4'hA, "R11");
        for (int s = 12; s < 16; s++) wr(4'(s), 8'(8'h5A + s), "R11 upper write");
        for (int s = 12; s < 16; s++) rd(4'(s), "R11 upper read");

        // write-only aliases
        wr(4'h4, 8'hFE, "R10 target id");
        wr(4'h5, 8'h93, "R10 timeout");
        wr(4'h6, 8'h21, "R10 period");
        wr(4'h7, 8'h0F, "R10 offset");
        for (int s = 4; s < 8; s++) rd(4'(s), "R10 read side unchanged");

        // same-cycle collisions
        step(1, 0, 4'h5, 8'h00, 1, "R13 R8 intr read with done");
        rd(4'h4, "R13 status kept");
        step(1, 1, 4'h0, 8'h22, 1, "R13 R9 count write with done");
        rd(4'h4, "R13 tc kept");
        step(1, 1, 4'h2, 8'h77, 1, "R13 R12 push with done");
        rd(4'h7, "R13 fifo cleared");

        // chip reset
        wr(4'h2, 8'h44, "R12");
        wr(4'h3, 8'h82, "R7 chip reset");
        for (int s = 0; s < 16; s++) rd(4'(s), "R7 post reset read");

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] s;
            logic [7:0] d;
            bit w, dd, sl;
            sl = ($urandom_range(0, 3) != 0);
            w  = $urandom_range(0, 1);
            s  = 4'($urandom_range(0, 15));
            d  = 8'($urandom);
            if (s == 3 && w) d = {d[7], codes[$urandom_range(0, 11)][6:0]};
            if (s == 3 && w && d[6:0] == 7'h02 && $urandom_range(0, 3) != 0) d[6:0] = 7'h10;
            dd = ($urandom_range(0, 15) == 0);
            step(sl, w, s, d, dd, "R1 mixed traffic");
        end

        done = 1;
        finish_run();
    end

endmodule